// File: doc/BRIEF.md
# External Bus Read Cycle Sequencer

This block runs read cycles on an external parallel bus that uses Intel-style control strobes. An internal requester presents a 24-bit address, a flag that marks the access as memory or I/O, and the index of the chip select to use. The block then steps through four bus states, T1 to T4. Each state lasts two clocks, called half-states, so that the address strobe can fall in the middle of T1.

During a read the block drives the address, the chip select, ALE, RD, MREQ and IORQ. It inserts wait states while the external READY input is low. It captures the returned byte and reports it with a one-clock done pulse. All control strobes except ALE are active low.

A build parameter selects the bus style. In the separate style the data pins are only ever inputs. In the multiplexed style the low address byte is driven on the data pins for all of T1. The pins are then released before RD goes low.

Top module: `xbus_rd_seq`

## Requirements
- R1: After reset, busy and done are low, ALE is low, RD_n, MREQ_n and IORQ_n are high, every chip-select line is high, and data_oe is low.
- R2: A request is accepted only in a clock where busy is low. A req_valid seen while busy is high starts no further cycle and does not change the address on the bus.
- R3: The clock after acceptance is the first half of T1, and T1 lasts two clocks. In both halves the bus address equals the request address, and chip-select bit k (k being the request index, bit 0 is index 0) is the only line driven low. ALE is high only in the first half of T1.
- R4: In the separate style RD_n is low from the start of T2 until the end of the last T3. In the multiplexed style RD_n goes low one clock later, in the second half of T2.
- R5: From the start of T2 to the end of the last T3, MREQ_n is low when req_io is 0 and IORQ_n is low when req_io is 1. The two are never low together.
- R6: READY is sampled only at the clock edge that ends the second half of a T3. If it is low there, one more T3 (two clocks) follows. With N such wait states the cycle lasts 8+2N clocks.
- R7: rdata takes the value on data_in at the edge that ends the last T3. done is high for exactly the first clock of T4, which is clock 6+2N after acceptance when clocks are counted from 0.
- R8: Throughout T4, RD_n, MREQ_n, IORQ_n and all chip selects are inactive. busy stays high from the clock after acceptance through the end of T4 and is low 8+2N clocks after acceptance.
- R9: In the multiplexed style, data_oe is high and data_out equals address bits 7:0 for both halves of T1. data_oe is low from the start of T2 on.
- R10: In the separate style data_oe is never high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; each half-state lasts one clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted while busy is low |
| req_addr | input | ADDR_W | Read address |
| req_io | input | 1 | 1 = I/O access, 0 = memory access |
| req_cs | input | clog2(CS_N) | Chip-select index |
| busy | output | 1 | A bus cycle is in progress |
| done | output | 1 | One-clock pulse in the first half of T4 |
| rdata | output | DATA_W | Captured read byte |
| bus_addr | output | ADDR_W | External address bus |
| bus_cs_n | output | CS_N | Active-low chip selects |
| bus_ale | output | 1 | Address latch enable, active high |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_mreq_n | output | 1 | Active-low memory request |
| bus_iorq_n | output | 1 | Active-low I/O request |
| bus_ready | input | 1 | Active-high ready from the addressed device |
| bus_data_in | input | DATA_W | Data pins as seen from outside |
| bus_data_out | output | DATA_W | Value for the data pins (multiplexed style) |
| bus_data_oe | output | 1 | Output enable for the data pins |

## Verification
The bench presents different values on data_in before, during and after the capturing edge. A design that samples one clock early or late returns the wrong byte, and the scoreboard catches it. Runs with zero, one and three wait states would expose a design that tests READY in the wrong half of T3, or that drops or adds a wait state, because done would arrive off the expected clock. Both bus styles run side by side on the same stimulus. A late release of the data pins, or an RD that comes too early in the multiplexed style, shows up as a mismatch on the RD or output-enable clock. A request raised in the middle of a cycle checks that the sequencer does not restart, does not take the new address, and does not run a second cycle after the first.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_T4   = 3'd4
  } tstate_e;

  // ALE: first half of T1 only
  function automatic logic ale_phase(tstate_e st, logic half);
    return (st == PH_T1) && !half;
  endfunction

  // address phase: whole of T1 through T3 keeps the chip select low
  function automatic logic sel_phase(tstate_e st);
    return (st == PH_T1) || (st == PH_T2) || (st == PH_T3);
  endfunction

  // MREQ / IORQ window
  function automatic logic strobe_phase(tstate_e st);
    return (st == PH_T2) || (st == PH_T3);
  endfunction

  // RD window; the multiplexed style waits half a state for the pins to turn around
  function automatic logic rd_phase(tstate_e st, logic half, logic muxed);
    return (st == PH_T3) || ((st == PH_T2) && (!muxed || half));
  endfunction

  // next T-state at the end of a full state
  function automatic tstate_e next_state(tstate_e st, logic ready);
    case (st)
      PH_T1:   return PH_T2;
      PH_T2:   return PH_T3;
      PH_T3:   return ready ? PH_T4 : PH_T3;
      PH_T4:   return PH_IDLE;
      default: return PH_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/xbus_tseq.sv
module xbus_tseq
  import xbus_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    ready,
  output tstate_e state,
  output logic    half,
  output logic    evt_capture,
  output logic    evt_wait
);

  logic end_of_state;

  assign end_of_state = (state != PH_IDLE) && half;
  assign evt_capture  = end_of_state && (state == PH_T3) && ready;
  assign evt_wait     = end_of_state && (state == PH_T3) && !ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PH_IDLE;
      half  <= 1'b0;
    end else if (state == PH_IDLE) begin
      half <= 1'b0;
      if (start) state <= PH_T1;
    end else if (!half) begin
      half <= 1'b1;
    end else begin
      half  <= 1'b0;
      state <= next_state(state, ready);
    end
  end

endmodule

// File: rtl/xbus_req_hold.sv
module xbus_req_hold #(
  parameter int ADDR_W = 24,
  parameter int CS_N   = 4,
  localparam int CS_W  = (CS_N > 1) ? $clog2(CS_N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              io_in,
  input  logic [CS_W-1:0]   cs_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic              io_q,
  output logic [CS_N-1:0]   cs_hot
);

  logic [CS_W-1:0] cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      io_q   <= 1'b0;
      cs_q   <= '0;
    end else if (load) begin
      addr_q <= addr_in;
      io_q   <= io_in;
      cs_q   <= cs_in;
    end
  end

  for (genvar k = 0; k < CS_N; k++) begin : g_cs
    assign cs_hot[k] = (cs_q == CS_W'(k));
  end

endmodule

// File: rtl/xbus_pindrv.sv
module xbus_pindrv
  import xbus_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 8,
  parameter int CS_N    = 4,
  parameter bit MUX_BUS = 1'b0
) (
  input  tstate_e           state,
  input  logic              half,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic              io_q,
  input  logic [CS_N-1:0]   cs_hot,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [CS_N-1:0]   bus_cs_n,
  output logic              bus_ale,
  output logic              bus_rd_n,
  output logic              bus_mreq_n,
  output logic              bus_iorq_n,
  output logic [DATA_W-1:0] bus_data_out,
  output logic              bus_data_oe
);

  logic sel_on, strobe_on;

  assign sel_on     = sel_phase(state);
  assign strobe_on  = strobe_phase(state);
  assign bus_addr   = addr_q;
  assign bus_ale    = ale_phase(state, half);
  assign bus_rd_n   = !rd_phase(state, half, MUX_BUS);
  assign bus_mreq_n = !(strobe_on && !io_q);
  assign bus_iorq_n = !(strobe_on && io_q);
  assign bus_cs_n   = ~(cs_hot & {CS_N{sel_on}});

  if (MUX_BUS) begin : g_mux
    assign bus_data_oe  = (state == PH_T1);
    assign bus_data_out = addr_q[DATA_W-1:0];
  end else begin : g_sep
    assign bus_data_oe  = 1'b0;
    assign bus_data_out = '0;
  end

endmodule

// File: rtl/xbus_capture.sv
module xbus_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dout <= '0;
    else if (take) dout <= din;
  end

endmodule

// File: rtl/xbus_rd_seq.sv
module xbus_rd_seq
  import xbus_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 8,
  parameter int CS_N    = 4,
  parameter bit MUX_BUS = 1'b0
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   req_valid,
  input  logic [ADDR_W-1:0]                      req_addr,
  input  logic                                   req_io,
  input  logic [((CS_N > 1) ? $clog2(CS_N) : 1)-1:0] req_cs,
  output logic                                   busy,
  output logic                                   done,
  output logic [DATA_W-1:0]                      rdata,
  output logic [ADDR_W-1:0]                      bus_addr,
  output logic [CS_N-1:0]                        bus_cs_n,
  output logic                                   bus_ale,
  output logic                                   bus_rd_n,
  output logic                                   bus_mreq_n,
  output logic                                   bus_iorq_n,
  input  logic                                   bus_ready,
  input  logic [DATA_W-1:0]                      bus_data_in,
  output logic [DATA_W-1:0]                      bus_data_out,
  output logic                                   bus_data_oe
);

  tstate_e           state;
  logic              half;
  logic              evt_accept;
  logic              evt_capture;
  logic              evt_wait;
  logic [ADDR_W-1:0] addr_q;
  logic              io_q;
  logic [CS_N-1:0]   cs_hot;

  assign evt_accept = (state == PH_IDLE) && req_valid;
  assign busy       = (state != PH_IDLE);
  assign done       = (state == PH_T4) && !half;

  xbus_tseq u_tseq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (evt_accept),
    .ready       (bus_ready),
    .state       (state),
    .half        (half),
    .evt_capture (evt_capture),
    .evt_wait    (evt_wait)
  );

  xbus_req_hold #(.ADDR_W(ADDR_W), .CS_N(CS_N)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (evt_accept),
    .addr_in (req_addr),
    .io_in   (req_io),
    .cs_in   (req_cs),
    .addr_q  (addr_q),
    .io_q    (io_q),
    .cs_hot  (cs_hot)
  );

  xbus_pindrv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CS_N(CS_N), .MUX_BUS(MUX_BUS)) u_pins (
    .state        (state),
    .half         (half),
    .addr_q       (addr_q),
    .io_q         (io_q),
    .cs_hot       (cs_hot),
    .bus_addr     (bus_addr),
    .bus_cs_n     (bus_cs_n),
    .bus_ale      (bus_ale),
    .bus_rd_n     (bus_rd_n),
    .bus_mreq_n   (bus_mreq_n),
    .bus_iorq_n   (bus_iorq_n),
    .bus_data_out (bus_data_out),
    .bus_data_oe  (bus_data_oe)
  );

  xbus_capture #(.DATA_W(DATA_W)) u_cap (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (evt_capture),
    .din   (bus_data_in),
    .dout  (rdata)
  );

endmodule

// File: rtl/xbus_rd_seq_chk.sv
module xbus_rd_seq_chk #(
  parameter int CS_N    = 4,
  parameter bit MUX_BUS = 1'b0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic [CS_N-1:0] bus_cs_n,
  input logic            bus_ale,
  input logic            bus_rd_n,
  input logic            bus_mreq_n,
  input logic            bus_iorq_n,
  input logic            bus_data_oe,
  input logic            evt_accept,
  input logic            evt_capture,
  input logic            evt_wait
);

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept |=> busy); // R2

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n)); // R3

  AST_ALE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |=> !bus_ale); // R3

  AST_ALE_WITH_CS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> !(&bus_cs_n)); // R3

  AST_RD_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> (!bus_mreq_n || !bus_iorq_n)); // R4

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_mreq_n && !bus_iorq_n)); // R5

  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    evt_wait |=> (!bus_rd_n && !done)); // R6

  AST_CAPTURE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_capture |=> (done && bus_rd_n && (&bus_cs_n))); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ((&bus_cs_n) && bus_rd_n && bus_mreq_n && bus_iorq_n && !bus_ale)); // R8

  if (MUX_BUS) begin : g_mux_chk
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
      bus_data_oe |-> bus_rd_n); // R9
  end else begin : g_sep_chk
    AST_SEP_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_data_oe); // R10
  end

endmodule

bind xbus_rd_seq xbus_rd_seq_chk #(.CS_N(CS_N), .MUX_BUS(MUX_BUS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done        (done),
  .bus_cs_n    (bus_cs_n),
  .bus_ale     (bus_ale),
  .bus_rd_n    (bus_rd_n),
  .bus_mreq_n  (bus_mreq_n),
  .bus_iorq_n  (bus_iorq_n),
  .bus_data_oe (bus_data_oe),
  .evt_accept  (evt_accept),
  .evt_capture (evt_capture),
  .evt_wait    (evt_wait)
);

// File: tb/xbus_rd_seq_bench.sv
module xbus_rd_seq_bench;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [23:0] req_addr = '0;
  logic        req_io = 1'b0;
  logic [1:0]  req_cs = '0;
  logic        ready = 1'b0;
  logic [7:0]  din = '0;

  logic        s_busy, s_done, s_ale, s_rd_n, s_mreq_n, s_iorq_n, s_oe;
  logic [7:0]  s_rdata, s_dout;
  logic [23:0] s_addr;
  logic [3:0]  s_cs_n;
  logic        m_busy, m_done, m_ale, m_rd_n, m_mreq_n, m_iorq_n, m_oe;
  logic [7:0]  m_rdata, m_dout;
  logic [23:0] m_addr;
  logic [3:0]  m_cs_n;

  int checks = 0;
  int errors = 0;
  logic [7:0] q_s[$];
  logic [7:0] q_m[$];

  always #(CLK_P/2) clk = ~clk;

  xbus_rd_seq #(.MUX_BUS(1'b0)) u_xbus_rd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_io(req_io), .req_cs(req_cs), .busy(s_busy), .done(s_done),
    .rdata(s_rdata), .bus_addr(s_addr), .bus_cs_n(s_cs_n), .bus_ale(s_ale),
    .bus_rd_n(s_rd_n), .bus_mreq_n(s_mreq_n), .bus_iorq_n(s_iorq_n),
    .bus_ready(ready), .bus_data_in(din), .bus_data_out(s_dout),
    .bus_data_oe(s_oe));

  xbus_rd_seq #(.MUX_BUS(1'b1)) u_xbus_rd_seq_mux (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_io(req_io), .req_cs(req_cs), .busy(m_busy), .done(m_done),
    .rdata(m_rdata), .bus_addr(m_addr), .bus_cs_n(m_cs_n), .bus_ale(m_ale),
    .bus_rd_n(m_rd_n), .bus_mreq_n(m_mreq_n), .bus_iorq_n(m_iorq_n),
    .bus_ready(ready), .bus_data_in(din), .bus_data_out(m_dout),
    .bus_data_oe(m_oe));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // scoreboard monitor: pops one expected byte per done pulse
  always @(negedge clk) begin
    if (rst_n && s_done) begin
      if (q_s.size() == 0) chk(1'b0, "R7 sep unexpected done", 1, 0);
      else begin
        logic [7:0] e;
        e = q_s.pop_front();
        chk(s_rdata == e, "R7 sep rdata", s_rdata, e);
      end
    end
    if (rst_n && m_done) begin
      if (q_m.size() == 0) chk(1'b0, "R7 mux unexpected done", 1, 0);
      else begin
        logic [7:0] e;
        e = q_m.pop_front();
        chk(m_rdata == e, "R7 mux rdata", m_rdata, e);
      end
    end
  end

  // called at a negedge while both instances are idle
  task automatic do_read(input logic [23:0] a, input logic io, input logic [1:0] cs,
                         input int nw, input logic [7:0] d, input bit poke);
    int len;
    len = 8 + 2*nw;
    q_s.push_back(d);
    q_m.push_back(d);
    req_valid = 1'b1; req_addr = a; req_io = io; req_cs = cs;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_io = ~io; req_cs = ~cs;
    for (int i = 0; i < len; i++) begin
      logic [3:0] cs_e;
      logic act, rd_s, rd_m;
      act  = (i < 6 + 2*nw);
      cs_e = act ? ~(4'b0001 << cs) : 4'hF;
      rd_s = !((i >= 2) && act);
      rd_m = !((i >= 3) && act);
      chk(s_addr == a && m_addr == a, "R3 address held", s_addr, a);
      chk(s_cs_n == cs_e && m_cs_n == cs_e, "R3 R8 chip select", s_cs_n, cs_e);
      chk(s_ale == (i == 0) && m_ale == (i == 0), "R3 ale", s_ale, (i == 0));
      chk(s_rd_n == rd_s, "R4 sep rd_n", s_rd_n, rd_s);
      chk(m_rd_n == rd_m, "R4 mux rd_n", m_rd_n, rd_m);
      chk(s_mreq_n == !(!io && !rd_s) && m_mreq_n == s_mreq_n, "R5 mreq_n", s_mreq_n, !(!io && !rd_s));
      chk(s_iorq_n == !(io && !rd_s) && m_iorq_n == s_iorq_n, "R5 iorq_n", s_iorq_n, !(io && !rd_s));
      chk(s_done == (i == 6 + 2*nw) && m_done == s_done, "R6 R7 done timing", s_done, (i == 6 + 2*nw));
      chk(s_busy && m_busy, "R8 busy during cycle", s_busy, 1);
      chk(s_oe == 1'b0, "R10 sep oe", s_oe, 0);
      chk(m_oe == (i < 2), "R9 mux oe", m_oe, (i < 2));
      if (i < 2) chk(m_dout == a[7:0], "R9 mux low address", m_dout, a[7:0]);
      ready = (i >= 4 + 2*nw);
      din   = (i == 5 + 2*nw) ? d : ~d;
      if (poke) begin
        req_valid = (i == 3);
        req_addr  = a ^ 24'h00F0F0;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    ready = 1'b0;
    chk(!s_busy && !m_busy, "R6 R8 busy low at 8+2N", s_busy, 0);
    if (poke) begin
      @(negedge clk);
      chk(!s_busy && !m_busy && (&s_cs_n) && (&m_cs_n), "R2 no second cycle", s_busy, 0);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    chk(1'b0, "watchdog R8", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!s_busy && !m_busy && !s_done && !m_done, "R1 busy/done at reset", s_busy, 0);
    chk(!s_ale && !m_ale && s_rd_n && m_rd_n, "R1 ale/rd at reset", s_rd_n, 1);
    chk(s_mreq_n && s_iorq_n && m_mreq_n && m_iorq_n, "R1 strobes at reset", s_mreq_n, 1);
    chk((&s_cs_n) && (&m_cs_n) && !s_oe && !m_oe, "R1 cs/oe at reset", s_cs_n, 4'hF);
    rst_n = 1'b1;
    @(negedge clk);
    do_read(24'h123456, 1'b0, 2'd0, 0, 8'hA5, 1'b0);
    do_read(24'hABCDEF, 1'b1, 2'd3, 1, 8'h3C, 1'b1);
    do_read(24'h00FF01, 1'b0, 2'd2, 3, 8'h81, 1'b0);
    do_read(24'hFEDC10, 1'b1, 2'd1, 2, 8'h5A, 1'b0);
    repeat (2) @(negedge clk);
    chk(q_s.size() == 0 && q_m.size() == 0, "R7 every read completed", q_s.size(), 0);
    chk(!s_busy && (&s_cs_n) && s_rd_n && !m_oe, "R8 idle after runs", s_busy, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule